// File: doc/BRIEF.md
# Dual-Point PWM Channel Generator

This block produces one pulse-width-modulated output from two written words: a control word and a waveform word. A two-stage prescaler divides the input clock into a time quantum. An 8-bit position counter advances once per quantum and runs from zero up to a programmed terminal count. Two compare points, a start point and a stop point, set where the output is active inside each period. The two points may lie in either order, which allows a window that wraps around the period boundary. When the two points are equal, the output is active for the whole period.

Writes to the waveform word first land in a staging register. By default they move into the working registers only when the position counter wraps, so a period never mixes old and new settings. A control bit makes the transfer immediate instead.

Separate control bits cover four things: counting (clock enable), driving the pin (pin enable), output polarity, and an open-drain pad mode. Polarity and pin-enable changes act within two clock cycles and do not wait for a period boundary.

Top module: `pwm_dualpoint_chan`

## Requirements
- R1: After reset, `pwm_o` is 0 and `pwm_oe` is 1, and the output stays inactive until the control word sets the clock-enable and pin-enable bits.
- R2: The control word holds the low divider L at bits 7:0 and the exponent H at bits 11:8. One quantum lasts (L+1)<<H input clocks. The waveform word holds the terminal count P at bits 31:24, and a period lasts (P+1) quanta, so the output repeats every (P+1)*((L+1)<<H) clocks.
- R3: The waveform word holds the start point S at bits 7:0 and the stop point E at bits 15:8. With S<E the output is active while the position is in [S,E). With S>E it is active while the position is at least S or below E. Each active position lasts one quantum.
- R4: When S equals E, the output is active for the entire period.
- R5: Clearing the clock-enable bit (bit 16) holds the prescaler and the position counter at zero and makes the output inactive within two cycles. Waveform words written in the meantime take effect on re-enable. The first quantum after re-enable is full length, and the position starts at zero.
- R6: Clearing the pin-enable bit (bit 12) puts the inactive level on the output within two cycles, without finishing the current period.
- R7: The invert bit (bit 14) makes 1 the inactive level and flips the output within two cycles, without waiting for a period boundary.
- R8: With the sync-disable bit (bit 17) clear, a waveform write takes effect at the next period boundary, and the current period completes with the old values.
- R9: With the sync-disable bit set, a waveform write changes the output within the current period, two cycles after the write.
- R10: With the open-drain bit (bit 13) set, `pwm_o` is held at 0 and `pwm_oe` is the inverse of the output level: the pad is pulled low for level 0 and released for level 1. With the bit clear, `pwm_oe` is 1 and `pwm_o` carries the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word |
| wave_we | input | 1 | Write strobe for the waveform word |
| wave_wdata | input | 32 | Waveform word (start, stop, terminal count) |
| pwm_o | output | 1 | Registered pad data |
| pwm_oe | output | 1 | Registered pad output enable |

## Verification
Every start/stop pair is swept for two terminal counts at a fixed quantum. Counting active clocks over a window that spans whole periods separates in-order windows, wrapped windows and the equal-points case, independent of phase. A sweep of divider and exponent at a fixed window checks both the active count and the spacing of rising edges, which tells an error in the quantum apart from an error in the period. A waveform is rewritten just after a rising edge, once with sync on and once with sync off. The current and next pulse widths then show whether the change waited for the boundary. A long quantum isolates the polarity, pin-enable and open-drain controls from any period boundary.

// File: rtl/pwmdp_pkg.sv
package pwmdp_pkg;
  localparam int DIVL_W = 8;
  localparam int DIVH_W = 4;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic              sync_off;
    logic              clk_on;
    logic              inv;
    logic              od;
    logic              pin_on;
    logic [DIVH_W-1:0] div_hi;
    logic [DIVL_W-1:0] div_lo;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] stop;
    logic [CNT_W-1:0] start;
  } wave_t;

  function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.div_lo   = w[7:0];
    c.div_hi   = w[11:8];
    c.pin_on   = w[12];
    c.od       = w[13];
    c.inv      = w[14];
    c.clk_on   = w[16];
    c.sync_off = w[17];
    return c;
  endfunction

  function automatic wave_t unpack_wave(input logic [31:0] w);
    wave_t v;
    v.start = w[7:0];
    v.stop  = w[15:8];
    v.per   = w[31:24];
    return v;
  endfunction
endpackage

// File: rtl/pwmdp_prescaler.sv
module pwmdp_prescaler #(
  parameter int DIVL_W = pwmdp_pkg::DIVL_W,
  parameter int DIVH_W = pwmdp_pkg::DIVH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DIVL_W-1:0] div_lo,
  input  logic [DIVH_W-1:0] div_hi,
  output logic              tick
);
  localparam int QW = DIVL_W + (1 << DIVH_W);

  logic [QW-1:0] q_cnt;
  logic [QW-1:0] q_len;

  always_comb begin
    q_len = (QW'(div_lo) + QW'(1)) << div_hi;
    tick  = run && (q_cnt >= q_len - QW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) q_cnt <= '0;
    else                     q_cnt <= q_cnt + QW'(1);
  end

  // R5: an idle prescaler restarts so the next quantum is full length
  p_idle_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (q_cnt == '0));
endmodule

// File: rtl/pwmdp_wave.sv
module pwmdp_wave #(
  parameter int CNT_W = pwmdp_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sync_off,
  input  logic             tick,
  input  logic [CNT_W-1:0] stg_start,
  input  logic [CNT_W-1:0] stg_stop,
  input  logic [CNT_W-1:0] stg_per,
  output logic             hot
);
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] w_start, w_stop, w_per;
  logic             wrap, load, in_win;

  always_comb begin
    wrap = tick && (pos >= w_per);
    load = !run || sync_off || wrap;
    if (w_start == w_stop)     in_win = 1'b1;
    else if (w_start < w_stop) in_win = (pos >= w_start) && (pos < w_stop);
    else                       in_win = (pos >= w_start) || (pos < w_stop);
    hot = run && in_win;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  pos <= '0;
    else if (wrap)    pos <= '0;
    else if (tick)    pos <= pos + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_start <= '0;
      w_stop  <= '0;
      w_per   <= '0;
    end else if (load) begin
      w_start <= stg_start;
      w_stop  <= stg_stop;
      w_per   <= stg_per;
    end
  end

  // R8: working values only change at a period boundary while sync is on
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !sync_off && !wrap) |=> $stable({w_start, w_stop, w_per}));
  // R5: a stopped channel restarts counting from position zero
  p_pos_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pos == '0));
  // R2: the position never runs past the terminal count while it is stable
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !sync_off && pos <= w_per && !load) |=> (pos <= w_per));
endmodule

// File: rtl/pwmdp_outstage.sv
module pwmdp_outstage (
  input  logic clk,
  input  logic rst,
  input  logic hot,
  input  logic pin_on,
  input  logic inv,
  input  logic od,
  output logic pad_o,
  output logic pad_oe
);
  logic lvl;

  always_comb lvl = pin_on ? (hot ^ inv) : inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b1;
    end else begin
      pad_o  <= od ? 1'b0 : lvl;
      pad_oe <= od ? ~lvl : 1'b1;
    end
  end

  // R10: open-drain mode never drives a high data value
  p_od_data_r10: assert property (@(posedge clk) disable iff (rst)
    $past(od) |-> !pad_o);
  // R10: push-pull mode always drives the pad
  p_pp_enable_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(od) |-> pad_oe);
endmodule

// File: rtl/pwm_dualpoint_chan.sv
module pwm_dualpoint_chan #(
  parameter int DIVL_W = pwmdp_pkg::DIVL_W,
  parameter int DIVH_W = pwmdp_pkg::DIVH_W,
  parameter int CNT_W  = pwmdp_pkg::CNT_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        wave_we,
  input  logic [31:0] wave_wdata,
  output logic        pwm_o,
  output logic        pwm_oe
);
  import pwmdp_pkg::*;

  ctrl_t ctl_q;
  wave_t stg_q;
  logic  tick, hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      stg_q <= '0;
    end else begin
      if (ctrl_we) ctl_q <= unpack_ctrl(ctrl_wdata);
      if (wave_we) stg_q <= unpack_wave(wave_wdata);
    end
  end

  pwmdp_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) presc_i (
    .clk(clk), .rst(rst), .run(ctl_q.clk_on),
    .div_lo(ctl_q.div_lo), .div_hi(ctl_q.div_hi), .tick(tick));

  pwmdp_wave #(.CNT_W(CNT_W)) wave_i (
    .clk(clk), .rst(rst), .run(ctl_q.clk_on), .sync_off(ctl_q.sync_off),
    .tick(tick), .stg_start(stg_q.start), .stg_stop(stg_q.stop),
    .stg_per(stg_q.per), .hot(hot));

  pwmdp_outstage out_i (
    .clk(clk), .rst(rst), .hot(hot), .pin_on(ctl_q.pin_on),
    .inv(ctl_q.inv), .od(ctl_q.od), .pad_o(pwm_o), .pad_oe(pwm_oe));

  // R6: a disabled pin shows only the inactive level on the next cycle
  p_pin_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.pin_on && !ctl_q.od) |=> (pwm_o == $past(ctl_q.inv)));
  // R7: with counting stopped the pad follows the polarity bit
  p_idle_polarity_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.clk_on && !ctl_q.od) |=> (pwm_o == $past(ctl_q.inv)));
endmodule

// File: tb/pwm_dualpoint_chan_tb.sv
`timescale 1ns/1ps
module pwm_dualpoint_chan_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we = 1'b0, wave_we = 1'b0;
  logic [31:0] ctrl_wdata = '0, wave_wdata = '0;
  logic pwm_o, pwm_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dualpoint_chan dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .wave_we(wave_we), .wave_wdata(wave_wdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe));

  function automatic logic [31:0] cw(int dl, int dh, bit pin, bit od, bit inv, bit ck, bit snc);
    return {14'd0, snc, ck, 1'b0, inv, od, pin, dh[3:0], dl[7:0]};
  endfunction

  function automatic logic [31:0] ww(int per, int s, int e);
    return {per[7:0], 8'd0, e[7:0], s[7:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_ctrl(logic [31:0] w);
    ctrl_wdata = w; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic put_wave(logic [31:0] w);
    wave_wdata = w; wave_we = 1'b1;
    @(negedge clk); wave_we = 1'b0;
  endtask

  task automatic count_ones(int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) ones++;
    end
  endtask

  task automatic wait_rise();
    while (pwm_o !== 1'b0) @(negedge clk);
    while (pwm_o !== 1'b1) @(negedge clk);
  endtask

  task automatic run_len(output int n);
    wait_rise();
    n = 0;
    while (pwm_o === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic rise_gap(output int n);
    wait_rise();
    n = 0;
    @(negedge clk);
    while (pwm_o !== 1'b0) begin n++; @(negedge clk); end
    while (pwm_o !== 1'b1) begin n++; @(negedge clk); end
    n++;
  endtask

  task automatic restart(int dl, int dh, int per, int s, int e, bit snc);
    put_ctrl(cw(dl, dh, 1, 0, 0, 0, snc));
    put_wave(ww(per, s, e));
    put_ctrl(cw(dl, dh, 1, 0, 0, 1, snc));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int ones, q, len, a, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_o", int'(pwm_o), 0);
    check("R1 pwm_oe", int'(pwm_oe), 1);
    count_ones(20, ones);
    check("R1 idle", ones, 0);

    // R3/R4 sweep of start/stop pairs, quantum 2 clocks
    for (int per = 3; per <= 4; per++)
      for (int s = 0; s <= per; s++)
        for (int e = 0; e <= per; e++) begin
          restart(1, 0, per, s, e, 0);
          len = 2 * (per + 1);
          if (s == e)      a = per + 1;
          else if (s < e)  a = e - s;
          else             a = (per + 1 - s) + e;
          count_ones(len, ones);
          check((s == e) ? "R4 full duty" : "R3 window", ones, 2 * a);
        end

    // R2 divider/exponent sweep, window [1,3) of period 4 positions
    for (int dl = 0; dl <= 3; dl++)
      for (int dh = 0; dh <= 2; dh++) begin
        q = (dl + 1) << dh;
        restart(dl, dh, 3, 1, 3, 0);
        count_ones(4 * q, ones);
        check("R2 active clocks", ones, 2 * q);
        rise_gap(n);
        check("R2 period clocks", n, 4 * q);
      end
    restart(9, 3, 2, 0, 1, 0);
    rise_gap(n);
    check("R2 long quantum period", n, 3 * 80);

    // R5 clock enable off, rewrite, re-enable
    restart(2, 0, 3, 0, 1, 0);
    put_ctrl(cw(2, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    check("R5 inactive when stopped", int'(pwm_o), 0);
    count_ones(30, ones);
    check("R5 held idle", ones, 0);
    put_wave(ww(3, 0, 2));
    put_ctrl(cw(2, 0, 1, 0, 0, 1, 0));
    n = 0;
    @(negedge clk);
    while (pwm_o === 1'b1) begin n++; @(negedge clk); end
    check("R5 first pulse after enable", n, 6);

    // R8 sync on: rewrite just after a rising edge
    restart(1, 0, 3, 0, 2, 0);
    wait_rise();
    wave_wdata = ww(3, 0, 3); wave_we = 1'b1;
    n = 1;
    forever begin
      @(negedge clk); wave_we = 1'b0;
      if (pwm_o === 1'b1) n++; else break;
    end
    check("R8 current period keeps old width", n, 4);
    run_len(n);
    check("R8 next period new width", n, 6);

    // R9 sync off: same rewrite applies in the current period
    restart(1, 0, 3, 0, 2, 1);
    wait_rise();
    wave_wdata = ww(3, 0, 3); wave_we = 1'b1;
    n = 1;
    forever begin
      @(negedge clk); wave_we = 1'b0;
      if (pwm_o === 1'b1) n++; else break;
    end
    check("R9 immediate width change", n, 6);

    // Long quantum, full duty: polarity, pin enable, open drain
    restart(255, 4, 3, 0, 0, 0);
    check("R4 full duty level", int'(pwm_o), 1);
    put_ctrl(cw(255, 4, 0, 0, 0, 1, 0));
    @(negedge clk);
    check("R6 pin off mid period", int'(pwm_o), 0);
    count_ones(20, ones);
    check("R6 stays inactive", ones, 0);
    put_ctrl(cw(255, 4, 1, 0, 0, 1, 0));
    @(negedge clk);
    check("R6 pin back on", int'(pwm_o), 1);
    put_ctrl(cw(255, 4, 1, 0, 1, 1, 0));
    @(negedge clk);
    check("R7 invert flips at once", int'(pwm_o), 0);
    put_ctrl(cw(255, 4, 0, 0, 1, 1, 0));
    @(negedge clk);
    check("R7 inverted inactive level", int'(pwm_o), 1);
    put_ctrl(cw(255, 4, 1, 1, 0, 1, 0));
    @(negedge clk);
    check("R10 od data low", int'(pwm_o), 0);
    check("R10 od released for level 1", int'(pwm_oe), 0);
    put_ctrl(cw(255, 4, 0, 1, 0, 1, 0));
    @(negedge clk);
    check("R10 od pulls low for level 0", int'(pwm_oe), 1);
    check("R10 od data still low", int'(pwm_o), 0);
    put_ctrl(cw(255, 4, 1, 0, 0, 1, 0));
    @(negedge clk);
    check("R10 push-pull drives", int'(pwm_oe), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule